// File: doc/BRIEF.md
# Fault Status and Mask Register

This block is one byte-wide register on a simple internal register bus. It watches four fault conditions coming from the analog side of a power path: input overvoltage, an input undervoltage event, battery undervoltage lockout and battery overcurrent. Each condition is captured into a read-only flag. The rule for clearing a flag depends on the fault. Two flags stay set while their condition persists. One flag is a one-shot that fires on a new event. One flag is a latch that a read clears. The lower half of the same byte holds four writable mask bits, one per fault.

Software reads the byte to learn which faults occurred. That read is also the acknowledgement that clears the flags it is allowed to clear. A registered interrupt request stays asserted while any flag is set and its mask bit is clear. The serial bus protocol, the comparators that detect the faults and all other registers are outside this block.

Top module: `fault_status_reg`

## Requirements
- R1: The register answers only at address 0x01. A read at any other address returns 0x00 and clears no flag. A write at any other address leaves the mask unchanged. Layout: bit 7 = overvoltage flag, bit 6 = undervoltage flag, bit 5 = battery lockout flag, bit 4 = overcurrent flag, bits 3..0 = masks for the same faults in the same order.
- R2: After reset all eight bits read 0x00 and the interrupt output is 0.
- R3: The overvoltage flag (bit 7) reads 1 from the cycle after its condition asserts. It keeps reading 1 across any number of reads while the condition stays asserted.
- R4: The battery lockout flag (bit 5) behaves the same way as the overvoltage flag, while the lockout condition is present.
- R5: The undervoltage flag (bit 6) is set by a rising edge of the undervoltage event input. The first read returns 1 and clears it. While the input stays high it does not set again; a new 0-to-1 transition is needed.
- R6: The overcurrent flag (bit 4) is latched when the overcurrent input is high. It stays set after the input drops and is cleared by a read.
- R7: When a level flag (bit 7 or bit 5) was set and its condition has gone away, the next read returns 1 and the read after that returns 0.
- R8: If a fault is present in the same cycle as a clearing read, the flag stays set, so that event is reported on the following read.
- R9: A write to address 0x01 loads bits 3..0 into the mask. A mask bit of 1 masks its fault. Write data in bits 7..4 is ignored, and a write does not alter any flag.
- R10: The interrupt output is the OR over the four faults of (flag AND NOT mask). It is registered, so it follows a change in flags or mask one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; the clearing side effect happens at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not selected |
| ov_cond | input | 1 | Input overvoltage condition (level) |
| uv_event | input | 1 | Input undervoltage event (rising edge sets the flag) |
| batuv_cond | input | 1 | Battery undervoltage lockout condition (level) |
| ocp_event | input | 1 | Battery overcurrent event |
| fault_irq | output | 1 | Registered interrupt request for unmasked faults |

## Verification
The hardest case to reach is a clearing read that lands in the same clock cycle as a fault. The bench creates it by driving the overcurrent input and the read strobe on the same falling edge. It then checks that the flag survives into a second read and goes away only on a third. A second hard case is a level fault that is still held at its input when software reads. The bench keeps the overvoltage and lockout conditions asserted across back-to-back reads, and keeps the undervoltage input high across reads to show that no edge means no new flag. It then releases each input and shows the single trailing 1.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   // How a fault flag is set; every flag is cleared by a read unless it is being set
   typedef enum logic {
      RULE_LEVEL = 1'b0,   // set in every cycle the condition is high
      RULE_EDGE  = 1'b1    // set only on a 0->1 transition of the condition
   } clr_rule_e;

   // Fault index inside the packed fault vector; status bit = index + NUM_FAULTS
   localparam int unsigned FLT_OCP   = 0;
   localparam int unsigned FLT_BATUV = 1;
   localparam int unsigned FLT_UV    = 2;
   localparam int unsigned FLT_OV    = 3;
   localparam int unsigned NUM_FAULTS = 4;

   function automatic clr_rule_e rule_for(input logic [NUM_FAULTS-1:0] edge_map,
                                          input int unsigned idx);
      return edge_map[idx] ? RULE_EDGE : RULE_LEVEL;
   endfunction

endpackage

// File: rtl/fsr_flag_cell.sv
module fsr_flag_cell #(
   parameter fsr_pkg::clr_rule_e RULE = fsr_pkg::RULE_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic rd_clr,
   output logic flag
);
   logic set_ev;

   generate
      if (RULE == fsr_pkg::RULE_EDGE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= cond;
         end
         assign set_ev = cond & ~prev_q;
      end else begin : g_level
         assign set_ev = cond;
      end
   endgenerate

   // a set in the same cycle as a clearing read takes priority
   always_ff @(posedge clk) begin
      if (!rst_n)      flag <= 1'b0;
      else if (set_ev) flag <= 1'b1;
      else if (rd_clr) flag <= 1'b0;
   end
endmodule

// File: rtl/fsr_mask_reg.sv
module fsr_mask_reg #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] mask
);
   always_ff @(posedge clk) begin
      if (!rst_n)     mask <= '0;
      else if (wr_en) mask <= wdata;
   end
endmodule

// File: rtl/fsr_irq_gen.sv
module fsr_irq_gen #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] flags,
   input  logic [WIDTH-1:0] mask,
   output logic             irq
);
   logic [WIDTH-1:0] live;
   assign live = flags & ~mask;

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |live;
   end
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'h01,
   parameter logic [3:0]  EDGE_MAP = 4'b0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ov_cond,
   input  logic              uv_event,
   input  logic              batuv_cond,
   input  logic              ocp_event,
   output logic              fault_irq
);
   import fsr_pkg::*;

   localparam int unsigned NF = NUM_FAULTS;

   generate
      if (DATA_W != 2 * NF) begin : g_bad_width
         $error("fault_status_reg: DATA_W must equal twice the fault count");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("fault_status_reg: ADDR_W must be at least 1");
      end
   endgenerate

   logic          hit;
   logic          rd_hit;
   logic          wr_hit;
   logic [NF-1:0] cond_vec;
   logic [NF-1:0] flag_q;
   logic [NF-1:0] mask_q;
   logic          unused_wdata_hi;

   assign hit    = (bus_addr == REG_ADDR);
   assign rd_hit = bus_rd & hit;
   assign wr_hit = bus_wr & hit;

   always_comb begin
      cond_vec            = '0;
      cond_vec[FLT_OV]    = ov_cond;
      cond_vec[FLT_UV]    = uv_event;
      cond_vec[FLT_BATUV] = batuv_cond;
      cond_vec[FLT_OCP]   = ocp_event;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NF; gi++) begin : g_flag
         fsr_flag_cell #(
            .RULE (rule_for(EDGE_MAP, gi))
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond   (cond_vec[gi]),
            .rd_clr (rd_hit),
            .flag   (flag_q[gi])
         );
      end
   endgenerate

   fsr_mask_reg #(.WIDTH(NF)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_hit),
      .wdata (bus_wdata[NF-1:0]),
      .mask  (mask_q)
   );

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NF];

   fsr_irq_gen #(.WIDTH(NF)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flag_q),
      .mask  (mask_q),
      .irq   (fault_irq)
   );

   assign bus_rdata = rd_hit ? {flag_q, mask_q} : '0;
endmodule

// File: rtl/fault_status_reg_chk.sv
module fault_status_reg_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'h01
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              ov_cond,
   input logic              uv_event,
   input logic              ocp_event,
   input logic [3:0]        flag_q,
   input logic [3:0]        mask_q,
   input logic              fault_irq
);
   logic c_rd;
   logic c_wr;
   assign c_rd = bus_rd && (bus_addr == REG_ADDR);
   assign c_wr = bus_wr && (bus_addr == REG_ADDR);

   p_ov_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ov_cond |=> flag_q[3]);

   p_uv_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_rd && !uv_event) |=> !flag_q[2]);

   p_ocp_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[0] && !c_rd) |=> flag_q[0]);

   p_ov_trailing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (c_rd && !ov_cond) |=> !flag_q[3]);

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ocp_event && c_rd) |=> flag_q[0]);

   p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ocp_event && !flag_q[0]) |=> !flag_q[0]);

   p_mask_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      c_wr |=> (mask_q == $past(bus_wdata[3:0])));

   p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !c_wr |=> $stable(mask_q));

   p_irq_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & ~mask_q) != 4'b0) |=> fault_irq);

   p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & ~mask_q) == 4'b0) |=> !fault_irq);
endmodule

bind fault_status_reg fault_status_reg_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .REG_ADDR (REG_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .ov_cond   (ov_cond),
   .uv_event  (uv_event),
   .ocp_event (ocp_event),
   .flag_q    (flag_q),
   .mask_q    (mask_q),
   .fault_irq (fault_irq)
);

// File: tb/fault_status_reg_test.sv
`timescale 1ns/1ps
module fault_status_reg_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ov_cond = 1'b0;
   logic       uv_event = 1'b0;
   logic       batuv_cond = 1'b0;
   logic       ocp_event = 1'b0;
   logic       fault_irq;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   fault_status_reg uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ov_cond(ov_cond), .uv_event(uv_event), .batuv_cond(batuv_cond),
      .ocp_event(ocp_event), .fault_irq(fault_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   // All tasks start and end on a falling edge
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = 8'h00;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] v);
      bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(8'h01, d);
      chk("R2 reset value", d, 8'h00);
      chk("R2 reset irq", {7'b0, fault_irq}, 8'h00);
   endtask

   task automatic t_ov();
      logic [7:0] d;
      ov_cond = 1'b1; idle(1);
      rd(8'h01, d); chk("R3 ov set", d, 8'h80);
      rd(8'h01, d); chk("R3 ov held across read", d, 8'h80);
      rd(8'h01, d); chk("R3 ov held third read", d, 8'h80);
      ov_cond = 1'b0; idle(1);
      rd(8'h01, d); chk("R7 ov trailing one", d, 8'h80);
      rd(8'h01, d); chk("R7 ov cleared", d, 8'h00);
   endtask

   task automatic t_batuv();
      logic [7:0] d;
      batuv_cond = 1'b1; idle(2);
      rd(8'h01, d); chk("R4 lockout set", d, 8'h20);
      rd(8'h01, d); chk("R4 lockout held", d, 8'h20);
      batuv_cond = 1'b0; idle(1);
      rd(8'h01, d); chk("R7 lockout trailing one", d, 8'h20);
      rd(8'h01, d); chk("R7 lockout cleared", d, 8'h00);
   endtask

   task automatic t_uv();
      logic [7:0] d;
      uv_event = 1'b1; idle(1);
      rd(8'h01, d); chk("R5 uv set on edge", d, 8'h40);
      rd(8'h01, d); chk("R5 uv one-shot while held", d, 8'h00);
      idle(2);
      rd(8'h01, d); chk("R5 uv no re-set while held", d, 8'h00);
      uv_event = 1'b0; idle(1);
      uv_event = 1'b1; idle(1);
      rd(8'h01, d); chk("R5 uv new edge", d, 8'h40);
      uv_event = 1'b0;
      rd(8'h01, d); chk("R5 uv cleared", d, 8'h00);
   endtask

   task automatic t_ocp();
      logic [7:0] d;
      ocp_event = 1'b1; idle(1); ocp_event = 1'b0; idle(3);
      rd(8'h01, d); chk("R6 ocp latched", d, 8'h10);
      rd(8'h01, d); chk("R6 ocp read clear", d, 8'h00);
   endtask

   task automatic t_set_wins();
      logic [7:0] d;
      ocp_event = 1'b1; idle(1);
      // condition still high during the clearing read
      rd(8'h01, d); chk("R8 first read", d, 8'h10);
      ocp_event = 1'b0;
      rd(8'h01, d); chk("R8 set beat clear", d, 8'h10);
      rd(8'h01, d); chk("R8 then cleared", d, 8'h00);
   endtask

   task automatic t_decode();
      logic [7:0] d;
      ocp_event = 1'b1; idle(1); ocp_event = 1'b0;
      rd(8'h02, d); chk("R1 other address reads zero", d, 8'h00);
      wr(8'h02, 8'h0F);
      rd(8'h01, d); chk("R1 no clear or mask write elsewhere", d, 8'h10);
      rd(8'h01, d); chk("R1 cleared by own read", d, 8'h00);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      wr(8'h01, 8'hFF);
      rd(8'h01, d); chk("R9 upper write ignored", d, 8'h0F);
      wr(8'h01, 8'h05);
      rd(8'h01, d); chk("R9 mask pattern", d, 8'h05);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr(8'h01, 8'h0F);
      ov_cond = 1'b1; idle(3);
      chk("R10 masked fault no irq", {7'b0, fault_irq}, 8'h00);
      wr(8'h01, 8'h07);
      chk("R10 irq one cycle after mask", {7'b0, fault_irq}, 8'h00);
      idle(1);
      chk("R10 irq asserted", {7'b0, fault_irq}, 8'h01);
      ov_cond = 1'b0;
      rd(8'h01, d); chk("R10 read shows flag and mask", d, 8'h87);
      chk("R10 irq lags clear", {7'b0, fault_irq}, 8'h01);
      idle(1);
      chk("R10 irq dropped", {7'b0, fault_irq}, 8'h00);
      wr(8'h01, 8'h00);
      ocp_event = 1'b1; idle(1); ocp_event = 1'b0; idle(1);
      chk("R10 unmasked ocp irq", {7'b0, fault_irq}, 8'h01);
      rd(8'h01, d); chk("R10 ocp read", d, 8'h10);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ov();
      t_batuv();
      t_uv();
      t_ocp();
      t_set_wins();
      t_decode();
      t_mask();
      wr(8'h01, 8'h00);
      t_irq();
      idle(2);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule